// File: doc/BRIEF.md
# SMBus Line-State Supervisor

This block sits beside the byte-level engine of an SMBus slave and watches the two bus wires for long-duration conditions that the engine cannot see. Both wires pass through a two-flop synchronizer and an agreement filter. Counters driven by a slow timing tick then measure how long the cleaned wires hold each state. The tick is nominally one per millisecond, and all duration parameters are counted in ticks.

The outputs are:
- a bus-off status for a long all-low bus, with its complement as a bus-available flag;
- a one-cycle request for offset auto-calibration after a much longer all-low episode;
- a one-cycle transaction-abort pulse, raised either by an over-long clock-low phase or by an over-long idle-high bus;
- a sticky flag set when the clock-low time held by either side within one message goes past its budget.

The companion engine supplies start and stop strobes and reports when the slave itself is holding the clock low. A configuration input switches off the idle-high rule.

Top module: `smbus_line_supervisor`

## Requirements
- R1: Each wire passes through two synchronizer flops and then a filter. The filter changes its output only after FILT_LEN consecutive synchronized samples agree, so a disturbance shorter than FILT_LEN clock cycles does not restart any duration count.
- R2: bus_off goes high one cycle after the all-low count reaches BUSOFF_TICKS ticks (default 2000) of both cleaned wires low without a break.
- R3: bus_off drops, and bus_avail rises, within FILT_LEN+5 clock cycles of either wire going high. bus_avail is 1 whenever bus_off is 0.
- R4: cal_req is a single-cycle pulse, raised once when both wires have been low for CAL_TICKS ticks (default 5000). It is raised again only after a wire has gone high and a new all-low episode has run its full length.
- R5: xact_abort pulses for one cycle on the tick that takes a single clock-low phase past TOUT_TICKS ticks (default 30). It pulses once per low phase.
- R6: xact_abort pulses for one cycle on the tick that takes a both-high period past IDLE_TICKS ticks (default 50). It pulses once per high period.
- R7: While idle_rst_dis is 1, a both-high period raises no abort.
- R8: Between a start and a stop, ticks spent with the clock low while slave_hold is 1 are summed. ext_ovr is set once the sum exceeds SEXT_TICKS (default 25).
- R9: Between a start and a stop, ticks spent with the clock low while slave_hold is 0 are summed. ext_ovr is set once the sum exceeds MEXT_TICKS (default 10), including when that time is split across several low phases.
- R10: ext_ovr stays set through a stop and is cleared by the next start. A start clears both sums, and it takes priority over a crossing in the same cycle. Clock-low time outside a message adds nothing.
- R11: All duration counts saturate instead of wrapping. After reset, bus_off=0, bus_avail=1, cal_req=0, xact_abort=0 and ext_ovr=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle timing tick, nominally 1 ms |
| scl_in | input | 1 | Raw bus clock wire |
| sda_in | input | 1 | Raw bus data wire |
| idle_rst_dis | input | 1 | 1 switches off the idle-high abort |
| start_seen | input | 1 | Start strobe from the protocol engine |
| stop_seen | input | 1 | Stop strobe from the protocol engine |
| slave_hold | input | 1 | 1 while this slave holds the clock low |
| bus_off | output | 1 | Long all-low bus state |
| bus_avail | output | 1 | Bus usable (not bus-off) |
| cal_req | output | 1 | One-cycle offset calibration request |
| xact_abort | output | 1 | One-cycle transaction abort |
| ext_ovr | output | 1 | Clock-extension budget overrun (sticky) |

## Verification
A start strobe and a slave-extension total stepping past its budget can fall on the same clock edge. In that case the start must win, leaving the sums cleared and ext_ovr low. The bench provokes this with its own model: it watches the model's slave-extension total and drives start on exactly the edge where a tick would take that total past SEXT_TICKS. It then confirms that ext_ovr stays low afterwards. The same per-cycle comparison also covers the all-low episode where the clock-low timeout fires long before bus-off and calibration.

// File: rtl/smbus_sup_pkg.sv
// Shared constants and helpers for the SMBus line-state supervisor.
package smbus_sup_pkg;
    localparam int LINE_SCL  = 0;
    localparam int LINE_SDA  = 1;
    localparam int NUM_LINES = 2;

    // Bit width needed to hold values 0..limit.
    function automatic int cnt_w(input int limit);
        return (limit < 2) ? 1 : $clog2(limit + 1);
    endfunction
endpackage

// File: rtl/sup_line_filter.sv
// Conditions one raw bus wire: two synchronizer flops, then an agreement
// filter that moves its output only when FILT_LEN samples in a row agree.
// Assumes the bus idles high, so every flop resets to 1. FILT_LEN >= 2.
module sup_line_filter #(
    parameter int FILT_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic clean
);
    logic                s1;
    logic                s2;
    logic [FILT_LEN-1:0] hist;

    // Synchronize, record history, and update the filtered level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1    <= 1'b1;
            s2    <= 1'b1;
            hist  <= '1;
            clean <= 1'b1;
        end else begin
            s1   <= raw;
            s2   <= s1;
            hist <= {hist[FILT_LEN-2:0], s2};
            if (&hist)
                clean <= 1'b1;
            else if (~|hist)
                clean <= 1'b0;
        end
    end

    // R1
    filt_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clean != $past(clean)) |-> ($past(hist) == {FILT_LEN{clean}}));
endmodule

// File: rtl/sup_tick_counter.sv
// Saturating duration counter: clears while clr is high, otherwise
// advances on inc until it holds at LIMIT. Never wraps.
module sup_tick_counter
    import smbus_sup_pkg::*;
#(
    parameter int LIMIT = 10,
    parameter int W     = cnt_w(LIMIT)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] TOP = W'(LIMIT);

    // Clear, count, or hold at the ceiling.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr)
            cnt <= '0;
        else if (inc && (cnt != TOP))
            cnt <= cnt + 1'b1;
    end

    // R11
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((cnt == TOP) && !clr) |=> (cnt == TOP));
endmodule

// File: rtl/sup_ext_meter.sv
// Sums the clock-low ticks held by each side inside one message (from a
// start to a stop) and raises a sticky overrun flag when either sum exceeds
// its budget. A start clears both sums and the flag, taking priority over
// a stop or a crossing in the same cycle.
module sup_ext_meter
    import smbus_sup_pkg::*;
#(
    parameter int SEXT_TICKS = 25,
    parameter int MEXT_TICKS = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic scl_low,
    input  logic slave_hold,
    input  logic start_seen,
    input  logic stop_seen,
    output logic ovr
);
    localparam int SW = cnt_w(SEXT_TICKS + 1);
    localparam int MW = cnt_w(MEXT_TICKS + 1);
    localparam logic [SW-1:0] S_LIM = SW'(SEXT_TICKS);
    localparam logic [MW-1:0] M_LIM = MW'(MEXT_TICKS);

    logic          in_msg;
    logic          low_tick;
    logic [SW-1:0] s_cnt;
    logic [MW-1:0] m_cnt;

    assign low_tick = in_msg && scl_low && tick;

    sup_tick_counter #(.LIMIT(SEXT_TICKS + 1), .W(SW)) u_slave_sum (
        .clk(clk), .rst_n(rst_n), .clr(start_seen),
        .inc(low_tick && slave_hold), .cnt(s_cnt));

    sup_tick_counter #(.LIMIT(MEXT_TICKS + 1), .W(MW)) u_master_sum (
        .clk(clk), .rst_n(rst_n), .clr(start_seen),
        .inc(low_tick && !slave_hold), .cnt(m_cnt));

    // Track whether a message is open.
    always_ff @(posedge clk) begin
        if (!rst_n)
            in_msg <= 1'b0;
        else if (start_seen)
            in_msg <= 1'b1;
        else if (stop_seen)
            in_msg <= 1'b0;
    end

    // Sticky overrun flag, cleared only by a start.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ovr <= 1'b0;
        else if (start_seen)
            ovr <= 1'b0;
        else if ((s_cnt > S_LIM) || (m_cnt > M_LIM))
            ovr <= 1'b1;
    end

    // R10
    start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_seen |=> !ovr);
    // R10
    ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr && !start_seen) |=> ovr);
endmodule

// File: rtl/smbus_line_supervisor.sv
// Top of the SMBus line-state supervisor. Cleans both wires, then times the
// all-low, clock-low and both-high states in ticks to drive bus-off,
// calibration request, abort and extension overrun outputs.
// Assumes CAL_TICKS > BUSOFF_TICKS and a tick at most once per cycle.
module smbus_line_supervisor
    import smbus_sup_pkg::*;
#(
    parameter int FILT_LEN     = 3,
    parameter int BUSOFF_TICKS = 2000,
    parameter int CAL_TICKS    = 5000,
    parameter int TOUT_TICKS   = 30,
    parameter int IDLE_TICKS   = 50,
    parameter int SEXT_TICKS   = 25,
    parameter int MEXT_TICKS   = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic scl_in,
    input  logic sda_in,
    input  logic idle_rst_dis,
    input  logic start_seen,
    input  logic stop_seen,
    input  logic slave_hold,
    output logic bus_off,
    output logic bus_avail,
    output logic cal_req,
    output logic xact_abort,
    output logic ext_ovr
);
    localparam int LW = cnt_w(CAL_TICKS);
    localparam int TW = cnt_w(TOUT_TICKS + 1);
    localparam int HW = cnt_w(IDLE_TICKS + 1);
    localparam logic [LW-1:0] BUSOFF_C = LW'(BUSOFF_TICKS);
    localparam logic [LW-1:0] CAL_C    = LW'(CAL_TICKS);
    localparam logic [TW-1:0] TOUT_C   = TW'(TOUT_TICKS);
    localparam logic [HW-1:0] IDLE_C   = HW'(IDLE_TICKS);

    logic [NUM_LINES-1:0] raw_lines;
    logic [NUM_LINES-1:0] clean;
    logic                 both_low;
    logic                 both_high;
    logic [LW-1:0]        low_cnt;
    logic [TW-1:0]        scl_cnt;
    logic [HW-1:0]        hi_cnt;
    logic                 cal_armed;
    logic                 cal_fire;
    logic                 tout_hit;
    logic                 idle_hit;

    assign raw_lines[LINE_SCL] = scl_in;
    assign raw_lines[LINE_SDA] = sda_in;

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        sup_line_filter #(.FILT_LEN(FILT_LEN)) u_filt (
            .clk(clk), .rst_n(rst_n), .raw(raw_lines[i]), .clean(clean[i]));
    end

    assign both_low  = ~|clean;
    assign both_high = &clean;

    sup_tick_counter #(.LIMIT(CAL_TICKS), .W(LW)) u_low_cnt (
        .clk(clk), .rst_n(rst_n), .clr(!both_low), .inc(tick), .cnt(low_cnt));

    sup_tick_counter #(.LIMIT(TOUT_TICKS + 1), .W(TW)) u_scl_cnt (
        .clk(clk), .rst_n(rst_n), .clr(clean[LINE_SCL]), .inc(tick), .cnt(scl_cnt));

    sup_tick_counter #(.LIMIT(IDLE_TICKS + 1), .W(HW)) u_hi_cnt (
        .clk(clk), .rst_n(rst_n), .clr(!both_high), .inc(tick), .cnt(hi_cnt));

    assign cal_fire = both_low && (low_cnt == CAL_C) && cal_armed;
    assign tout_hit = !clean[LINE_SCL] && tick && (scl_cnt == TOUT_C);
    assign idle_hit = both_high && tick && (hi_cnt == IDLE_C) && !idle_rst_dis;

    // Bus-off state follows the all-low duration.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bus_off <= 1'b0;
        else
            bus_off <= both_low && (low_cnt >= BUSOFF_C);
    end

    assign bus_avail = !bus_off;

    // Calibration request: one pulse per all-low episode, re-armed on release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cal_req   <= 1'b0;
            cal_armed <= 1'b1;
        end else begin
            cal_req <= cal_fire;
            if (!both_low)
                cal_armed <= 1'b1;
            else if (cal_fire)
                cal_armed <= 1'b0;
        end
    end

    // Abort pulse from clock-low timeout or idle-high reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            xact_abort <= 1'b0;
        else
            xact_abort <= tout_hit || idle_hit;
    end

    sup_ext_meter #(.SEXT_TICKS(SEXT_TICKS), .MEXT_TICKS(MEXT_TICKS)) u_ext (
        .clk(clk), .rst_n(rst_n), .tick(tick), .scl_low(!clean[LINE_SCL]),
        .slave_hold(slave_hold), .start_seen(start_seen), .stop_seen(stop_seen),
        .ovr(ext_ovr));

    // R4
    cal_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cal_req |=> !cal_req);
    // R4
    cal_in_busoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cal_req |-> bus_off);
    // R3
    busoff_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_off && !both_low) |=> !bus_off);
    // R5
    abort_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xact_abort |=> !xact_abort);
    // R7
    idle_dis_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xact_abort && $past(both_high)) |-> !$past(idle_rst_dis));
endmodule

// File: tb/sim_smbus_line_supervisor.sv
module sim_smbus_line_supervisor;
    localparam int CLK_PERIOD = 10;
    localparam int TICK_DIV   = 2;
    localparam int FL   = 3;
    localparam int BOFF = 2000;
    localparam int CALT = 5000;
    localparam int TOUT = 30;
    localparam int IDLE = 50;
    localparam int SEXT = 25;
    localparam int MEXT = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic scl_in = 1'b1, sda_in = 1'b1;
    logic idle_rst_dis = 1'b0, start_seen = 1'b0, stop_seen = 1'b0, slave_hold = 1'b0;
    logic bus_off, bus_avail, cal_req, xact_abort, ext_ovr;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    int tick_ph = 0;
    int n_cal = 0;
    int n_abort = 0;
    bit done = 0;

    smbus_line_supervisor #(
        .FILT_LEN(FL), .BUSOFF_TICKS(BOFF), .CAL_TICKS(CALT), .TOUT_TICKS(TOUT),
        .IDLE_TICKS(IDLE), .SEXT_TICKS(SEXT), .MEXT_TICKS(MEXT)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .scl_in(scl_in), .sda_in(sda_in),
        .idle_rst_dis(idle_rst_dis), .start_seen(start_seen), .stop_seen(stop_seen),
        .slave_hold(slave_hold), .bus_off(bus_off), .bus_avail(bus_avail),
        .cal_req(cal_req), .xact_abort(xact_abort), .ext_ovr(ext_ovr));

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference model state (behavioural, from the requirements).
    bit qs[$], qd[$];
    bit m_fs, m_fd, m_busoff, m_cal, m_armed, m_abort, m_inmsg, m_ovr;
    int m_lowc, m_sclc, m_hic, m_sx, m_mx;

    function automatic bit filt_next(bit q[$], bit cur);
        bit all1 = 1'b1;
        bit all0 = 1'b1;
        for (int j = 3; j < 3 + FL; j++) begin
            if (q[j]) all0 = 1'b0; else all1 = 1'b0;
        end
        if (all1) return 1'b1;
        if (all0) return 1'b0;
        return cur;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            qs.delete(); qd.delete();
            for (int j = 0; j < 4 + FL; j++) begin qs.push_back(1'b1); qd.push_back(1'b1); end
            m_fs = 1; m_fd = 1; m_busoff = 0; m_cal = 0; m_armed = 1; m_abort = 0;
            m_inmsg = 0; m_ovr = 0; m_lowc = 0; m_sclc = 0; m_hic = 0; m_sx = 0; m_mx = 0;
        end else begin
            bit blow, bhigh, nfs, nfd, ncal;
            qs.push_front(scl_in); qd.push_front(sda_in);
            void'(qs.pop_back()); void'(qd.pop_back());
            blow  = !m_fs && !m_fd;
            bhigh = m_fs && m_fd;
            nfs = filt_next(qs, m_fs);
            nfd = filt_next(qd, m_fd);
            ncal = blow && (m_lowc == CALT) && m_armed;
            m_busoff = blow && (m_lowc >= BOFF);
            m_armed  = !blow ? 1'b1 : (ncal ? 1'b0 : m_armed);
            m_cal    = ncal;
            m_abort  = (!m_fs && tick && m_sclc == TOUT) ||
                       (bhigh && tick && m_hic == IDLE && !idle_rst_dis);
            if (!blow) m_lowc = 0; else if (tick && m_lowc < CALT) m_lowc++;
            if (m_fs) m_sclc = 0; else if (tick && m_sclc < TOUT + 1) m_sclc++;
            if (!bhigh) m_hic = 0; else if (tick && m_hic < IDLE + 1) m_hic++;
            m_ovr = start_seen ? 1'b0 : (m_ovr || m_sx > SEXT || m_mx > MEXT);
            if (start_seen) begin
                m_sx = 0; m_mx = 0;
            end else if (m_inmsg && !m_fs && tick) begin
                if (slave_hold) begin if (m_sx < SEXT + 1) m_sx++; end
                else begin if (m_mx < MEXT + 1) m_mx++; end
            end
            m_inmsg = start_seen ? 1'b1 : (stop_seen ? 1'b0 : m_inmsg);
            m_fs = nfs; m_fd = nfd;
        end
    end

    task automatic chk(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            if (bad < 30) $display("FAIL %s t=%0t actual=%b expected=%b", req, $time, act, exp);
        end
    endtask

    // Tick generator and per-cycle comparison against the model.
    always @(negedge clk) begin
        cycles++;
        tick_ph = (tick_ph + 1) % TICK_DIV;
        tick = (tick_ph == 0);
        if (rst_n && !done) begin
            chk("R2 bus_off", bus_off, m_busoff);
            chk("R3 bus_avail", bus_avail, !m_busoff);
            chk("R4 cal_req", cal_req, m_cal);
            chk("R5 xact_abort", xact_abort, m_abort);
            chk("R8 ext_ovr", ext_ovr, m_ovr);
            if (cal_req) n_cal++;
            if (xact_abort) n_abort++;
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic ticks(input int n);
        cyc(n * TICK_DIV);
    endtask

    task automatic strobe_start();
        start_seen = 1'b1; cyc(1); start_seen = 1'b0;
    endtask

    task automatic strobe_stop();
        stop_seen = 1'b1; cyc(1); stop_seen = 1'b0;
    endtask

    always @(negedge clk) begin
        if (cycles > 190000 && !done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int base;
        bit hit;
        cyc(4);
        // R11 reset state
        chk("R11 reset bus_off", bus_off, 1'b0);
        chk("R11 reset bus_avail", bus_avail, 1'b1);
        chk("R11 reset cal_req", cal_req, 1'b0);
        chk("R11 reset xact_abort", xact_abort, 1'b0);
        chk("R11 reset ext_ovr", ext_ovr, 1'b0);
        rst_n = 1'b1;

        // R6: one abort for a long idle-high period
        base = n_abort; ticks(120);
        chk("R6 idle abort count", (n_abort - base) == 1, 1'b1);

        // R7: idle rule switched off
        idle_rst_dis = 1'b1;
        base = n_abort;
        scl_in = 1'b0; ticks(5); scl_in = 1'b1; ticks(120);
        chk("R7 no idle abort", (n_abort - base) == 0, 1'b1);
        idle_rst_dis = 1'b0;

        // R5: clock-low timeout, data high
        base = n_abort;
        scl_in = 1'b0; ticks(40);
        chk("R5 timeout abort count", (n_abort - base) == 1, 1'b1);
        chk("R5 no bus_off with data high", bus_off, 1'b0);
        scl_in = 1'b1; cyc(10);

        // R1, R2: all-low with a short glitch
        base = n_cal;
        scl_in = 1'b0; sda_in = 1'b0; ticks(1000);
        scl_in = 1'b1; cyc(2); scl_in = 1'b0;
        ticks(900);
        chk("R2 not yet bus_off", bus_off, 1'b0);
        ticks(200);
        chk("R1 glitch ignored, bus_off", bus_off, 1'b1);
        chk("R2 bus_avail low", bus_avail, 1'b0);
        sda_in = 1'b1; cyc(FL + 5);
        chk("R3 bus_off released", bus_off, 1'b0);
        chk("R3 bus_avail back", bus_avail, 1'b1);
        chk("R4 no cal in short episode", (n_cal - base) == 0, 1'b1);
        scl_in = 1'b1; cyc(10);

        // R4: calibration pulse, single per episode, re-armed on release
        base = n_cal;
        scl_in = 1'b0; sda_in = 1'b0; ticks(5200);
        chk("R4 cal once", (n_cal - base) == 1, 1'b1);
        ticks(200);
        chk("R4 no repeat (R11 saturation)", (n_cal - base) == 1, 1'b1);
        scl_in = 1'b1; ticks(10); scl_in = 1'b0; ticks(5100);
        chk("R4 re-armed", (n_cal - base) == 2, 1'b1);
        scl_in = 1'b1; sda_in = 1'b1; ticks(10);

        // R8: slave extension overrun, R10 sticky through stop
        strobe_start();
        slave_hold = 1'b1; scl_in = 1'b0; ticks(20);
        chk("R8 below slave budget", ext_ovr, 1'b0);
        ticks(10); slave_hold = 1'b0; scl_in = 1'b1; ticks(2);
        chk("R8 slave overrun", ext_ovr, 1'b1);
        strobe_stop(); ticks(3);
        chk("R10 sticky after stop", ext_ovr, 1'b1);
        strobe_start(); cyc(2);
        chk("R10 start clears", ext_ovr, 1'b0);

        // R9: master extension, split over two low phases
        scl_in = 1'b0; ticks(6); scl_in = 1'b1; ticks(2);
        chk("R9 below master budget", ext_ovr, 1'b0);
        scl_in = 1'b0; ticks(6); scl_in = 1'b1; ticks(3);
        chk("R9 master overrun", ext_ovr, 1'b1);
        strobe_stop();

        // R10: low time outside a message adds nothing
        strobe_start(); strobe_stop(); ticks(2);
        slave_hold = 1'b1; scl_in = 1'b0; ticks(40);
        scl_in = 1'b1; slave_hold = 1'b0; ticks(3);
        chk("R10 outside message", ext_ovr, 1'b0);

        // R10: start in the same cycle as a slave-budget crossing
        strobe_start();
        slave_hold = 1'b1; scl_in = 1'b0;
        hit = 0;
        for (int k = 0; k < 400 && !hit; k++) begin
            cyc(1);
            if (tick && m_inmsg && !m_fs && m_sx == SEXT) begin
                start_seen = 1'b1; hit = 1;
            end
        end
        cyc(1); start_seen = 1'b0;
        ticks(3); scl_in = 1'b1; slave_hold = 1'b0; ticks(3);
        chk("R10 crossing provoked", hit, 1'b1);
        chk("R10 start wins over crossing", ext_ovr, 1'b0);
        strobe_stop(); ticks(5);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule